// File: doc/BRIEF.md
# FP8 Block Layout Transposer

This block turns a square tile of 8-bit floating-point codes (1 sign bit, 4 exponent bits with bias 7, 3 mantissa bits), stored with one power-of-two scale per row, into the same tile stored column by column under one shared scale. It never dequantizes. The block first loads the tile in row-major order, one code per beat. On the first beat of each row it also takes that row's signed scale exponent, and it keeps a running maximum of those exponents. On a start pulse it streams the tile out transposed. For each element it lowers the exponent field by the gap between the tile's maximum scale exponent and that element's row exponent, so each output code encodes the same value under the common scale. Values pushed below the normal range become subnormals with round-to-nearest-even, or a signed zero.

Both data interfaces use valid/ready. A load beat is taken in any cycle where `ld_valid` and `ld_ready` are both high. An output beat completes in any cycle where `o_valid` and `o_ready` are both high. A stalled output beat holds all of its fields until it is taken. The tile edge `DIM` is a parameter. The default is 32 so that the elaborated storage stays small. Full-size 128-element tiles use the same RTL with `DIM=128`.

Top module: `fp8x_blk_xpose`

## Requirements
- R1: Load beats are accepted while `ld_ready` is high, which holds from reset until the beat that completes the tile (beat `DIM*DIM`). Beat i is the element at row i/DIM, column i%DIM. `ld_ready` stays low from that beat until the cycle in which `done` pulses.
- R2: A row's scale exponent is taken from `ld_sexp` only on the beat that carries column 0 of that row. `ld_sexp` has no effect on any other beat.
- R3: Every output beat of a tile carries in `o_sexp` the largest of that tile's row scale exponents, compared as two's-complement signed values.
- R4: Output beat j carries the element from row j%DIM, column j/DIM. `o_last` is high only on beat `DIM*DIM-1`.
- R5: Let k be the maximum scale exponent minus the element's row scale exponent. When the element's exponent field minus k is at least 1, the sign bit (bit 7) and the mantissa (bits 2:0) are kept, and bits 6:3 become the old exponent field minus k.
- R6: When that reduced exponent falls below 1, the result is the subnormal code (exponent field 0) nearest in value, with ties rounded to an even mantissa. Rounding up from mantissa 7 gives exponent field 1 with mantissa 0. A result that rounds to nothing becomes a zero with the input's sign.
- R7: A subnormal input (exponent field 0, mantissa not 0) is normalised before the reduction, so its value is what gets shifted. Zero codes (bits 6:0 equal to 0) and the NaN code (bits 6:0 all ones) pass through unchanged.
- R8: `start` is acted on only once a full tile is loaded and no read-out is running. A start pulse at any other time is ignored, and `o_valid` stays low outside a read-out.
- R9: While `o_valid` is high and `o_ready` is low, the block keeps `o_valid` high and holds `o_code`, `o_sexp` and `o_last` stable.
- R10: `done` is high for exactly one cycle: the cycle after the beat with `o_last` is accepted. `ld_ready` returns high in that same cycle.
- R11: After reset, `ld_ready` is high and `o_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Load beat offered |
| ld_ready | output | 1 | Block is accepting load beats |
| ld_code | input | 8 | Code of the offered element |
| ld_sexp | input | SW | Row scale exponent, signed; used on column-0 beats |
| start | input | 1 | Begin read-out of the loaded tile |
| done | output | 1 | One-cycle pulse after the last output beat is taken |
| o_valid | output | 1 | Output beat available |
| o_ready | input | 1 | Downstream takes the output beat |
| o_code | output | 8 | Rescaled code in column-major order |
| o_sexp | output | SW | Common scale exponent of the tile, signed |
| o_last | output | 1 | Final beat of the tile |

## Verification
The hardest cases to reach from the ports are exact rounding ties in the subnormal range and the carry from subnormal mantissa 7 into the lowest normal exponent. Random codes and scales seldom land on these. One tile therefore uses a scale gap of exactly one between rows and places chosen codes whose halved values sit exactly halfway between subnormal steps or just below the normal boundary. Other tiles use very wide scale gaps to force signed flushes to zero. Random downstream stalls hold beats on the final element, and stray start pulses and load offers are issued during loading, waiting and read-out.

// File: rtl/fp8x_pkg.sv
package fp8x_pkg;
  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_FULL  = 2'd1,
    PH_DRAIN = 2'd2
  } phase_t;

  localparam logic [6:0] NAN_MAG = 7'h7F;
endpackage

// File: rtl/fp8x_load_seq.sv
module fp8x_load_seq #(
  parameter int DIM = 32,
  parameter int SW  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fire,
  input  logic [SW-1:0]                sexp_in,
  output logic [$clog2(DIM*DIM)-1:0]   wr_addr,
  output logic [$clog2(DIM)-1:0]       wr_row,
  output logic                         row_head,
  output logic                         tile_full,
  output logic [SW-1:0]                max_sexp
);
  localparam int IW = $clog2(DIM);
  localparam int AW = $clog2(DIM*DIM);
  localparam logic [IW-1:0] LASTI = IW'(DIM-1);

  logic [IW-1:0] row_q, col_q;

  assign wr_row    = row_q;
  assign wr_addr   = AW'(row_q) * AW'(DIM) + AW'(col_q);
  assign row_head  = (col_q == '0);
  assign tile_full = fire && (row_q == LASTI) && (col_q == LASTI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q    <= '0;
      col_q    <= '0;
      max_sexp <= '0;
    end else if (fire) begin
      if (col_q == LASTI) begin
        col_q <= '0;
        row_q <= (row_q == LASTI) ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
      if (col_q == '0) begin
        if (row_q == '0 || $signed(sexp_in) > $signed(max_sexp))
          max_sexp <= sexp_in;
      end
    end
  end
endmodule

// File: rtl/fp8x_store.sv
module fp8x_store #(
  parameter int DIM = 32,
  parameter int SW  = 8
) (
  input  logic                         clk,
  input  logic                         code_we,
  input  logic [$clog2(DIM*DIM)-1:0]   code_wa,
  input  logic [7:0]                   code_wd,
  input  logic                         sc_we,
  input  logic [$clog2(DIM)-1:0]       sc_wa,
  input  logic [SW-1:0]                sc_wd,
  input  logic [$clog2(DIM*DIM)-1:0]   code_ra,
  input  logic [$clog2(DIM)-1:0]       sc_ra,
  output logic [7:0]                   code_rd,
  output logic [SW-1:0]                sc_rd
);
  localparam int DEPTH = DIM * DIM;

  logic [7:0]    codes [DEPTH];
  logic [SW-1:0] scales [DIM];

  always_ff @(posedge clk) begin
    if (code_we) codes[code_wa] <= code_wd;
  end

  always_ff @(posedge clk) begin
    if (sc_we) scales[sc_wa] <= sc_wd;
  end

  assign code_rd = codes[code_ra];
  assign sc_rd   = scales[sc_ra];
endmodule

// File: rtl/fp8x_exp_shift.sv
module fp8x_exp_shift #(
  parameter int SW = 8
) (
  input  logic [7:0]  code_in,
  input  logic [SW:0] k,
  output logic [7:0]  code_out
);
  import fp8x_pkg::*;
  localparam int NW = SW + 3;

  logic                 sgn;
  logic [3:0]           ein;
  logic [2:0]           man;
  logic [3:0]           sig;
  logic signed [NW-1:0] eff;
  logic signed [NW-1:0] ne;
  logic [NW-1:0]        sh;
  logic [2:0]           shc;
  logic [8:0]           ext;
  logic [3:0]           q;
  logic                 rnd;
  logic [3:0]           qr;

  always_comb begin
    sgn = code_in[7];
    ein = code_in[6:3];
    man = code_in[2:0];
    sig = {1'b1, man};
    eff = NW'(ein);
    if (ein == 4'd0) begin
      casez (man)
        3'b1??: begin sig = {man, 1'b0};         eff = '0; end
        3'b01?: begin sig = {man[1:0], 2'b00};   eff = '1; end
        3'b001: begin sig = 4'b1000;             eff = {{(NW-1){1'b1}}, 1'b0}; end
        default: begin sig = 4'b0000;            eff = '0; end
      endcase
    end
    ne  = eff - $signed({2'b00, k});
    sh  = NW'(1) - ne;
    shc = (sh > NW'(6)) ? 3'd6 : sh[2:0];
    ext = {sig, 5'b00000} >> shc;
    q   = ext[8:5];
    rnd = ext[4] && ((|ext[3:0]) || q[0]);
    qr  = q + {3'b000, rnd};

    if (code_in[6:0] == NAN_MAG || code_in[6:0] == 7'd0)
      code_out = code_in;
    else if (ne > 0)
      code_out = {sgn, ne[3:0], sig[2:0]};
    else
      code_out = {sgn, 3'b000, qr};
  end
endmodule

// File: rtl/fp8x_drain_seq.sv
module fp8x_drain_seq #(
  parameter int DIM = 32,
  parameter int SW  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         go,
  input  logic [7:0]                   new_code,
  input  logic [SW-1:0]                tile_sexp,
  input  logic                         o_ready,
  output logic [$clog2(DIM*DIM)-1:0]   rd_addr,
  output logic [$clog2(DIM)-1:0]       rd_row,
  output logic                         o_valid,
  output logic [7:0]                   o_code,
  output logic [SW-1:0]                o_sexp,
  output logic                         o_last,
  output logic                         fin,
  output logic                         done
);
  localparam int IW = $clog2(DIM);
  localparam int AW = $clog2(DIM*DIM);
  localparam logic [IW-1:0] LASTI = IW'(DIM-1);

  logic [IW-1:0] row_q, col_q;
  logic          pend;
  logic          fill;
  logic          at_end;

  assign rd_row  = row_q;
  assign rd_addr = AW'(row_q) * AW'(DIM) + AW'(col_q);
  assign at_end  = (row_q == LASTI) && (col_q == LASTI);
  assign fill    = pend && (!o_valid || o_ready);
  assign fin     = o_valid && o_ready && o_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      pend  <= 1'b0;
    end else if (go) begin
      row_q <= '0;
      col_q <= '0;
      pend  <= 1'b1;
    end else if (fill) begin
      if (at_end) begin
        pend <= 1'b0;
      end else if (row_q == LASTI) begin
        row_q <= '0;
        col_q <= col_q + 1'b1;
      end else begin
        row_q <= row_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_code  <= '0;
      o_sexp  <= '0;
      o_last  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= fin;
      if (fill) begin
        o_valid <= 1'b1;
        o_code  <= new_code;
        o_sexp  <= tile_sexp;
        o_last  <= at_end;
      end else if (o_ready) begin
        o_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fp8x_blk_xpose.sv
module fp8x_blk_xpose #(
  parameter int DIM = 32,
  parameter int SW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [7:0]    ld_code,
  input  logic [SW-1:0] ld_sexp,
  input  logic          start,
  output logic          done,
  output logic          o_valid,
  input  logic          o_ready,
  output logic [7:0]    o_code,
  output logic [SW-1:0] o_sexp,
  output logic          o_last
);
  import fp8x_pkg::*;
  localparam int IW = $clog2(DIM);
  localparam int AW = $clog2(DIM*DIM);

  phase_t        ph;
  logic          ld_fire;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [IW-1:0] wr_row, rd_row;
  logic          row_head, tile_full;
  logic [SW-1:0] max_sexp, row_sexp;
  logic [7:0]    raw_code, new_code;
  logic [SW:0]   k;
  logic          go, fin;

  assign ld_ready = (ph == PH_LOAD);
  assign ld_fire  = ld_valid && ld_ready;
  assign go       = start && (ph == PH_FULL);
  assign k        = {max_sexp[SW-1], max_sexp} - {row_sexp[SW-1], row_sexp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_LOAD;
    end else begin
      unique case (ph)
        PH_LOAD:  if (tile_full) ph <= PH_FULL;
        PH_FULL:  if (start)     ph <= PH_DRAIN;
        PH_DRAIN: if (fin)       ph <= PH_LOAD;
        default:                 ph <= PH_LOAD;
      endcase
    end
  end

  fp8x_load_seq #(.DIM(DIM), .SW(SW)) u_load (
    .clk(clk), .rst_n(rst_n), .fire(ld_fire), .sexp_in(ld_sexp),
    .wr_addr(wr_addr), .wr_row(wr_row), .row_head(row_head),
    .tile_full(tile_full), .max_sexp(max_sexp)
  );

  fp8x_store #(.DIM(DIM), .SW(SW)) u_store (
    .clk(clk),
    .code_we(ld_fire), .code_wa(wr_addr), .code_wd(ld_code),
    .sc_we(ld_fire && row_head), .sc_wa(wr_row), .sc_wd(ld_sexp),
    .code_ra(rd_addr), .sc_ra(rd_row),
    .code_rd(raw_code), .sc_rd(row_sexp)
  );

  fp8x_exp_shift #(.SW(SW)) u_shift (
    .code_in(raw_code), .k(k), .code_out(new_code)
  );

  fp8x_drain_seq #(.DIM(DIM), .SW(SW)) u_drain (
    .clk(clk), .rst_n(rst_n), .go(go), .new_code(new_code),
    .tile_sexp(max_sexp), .o_ready(o_ready),
    .rd_addr(rd_addr), .rd_row(rd_row),
    .o_valid(o_valid), .o_code(o_code), .o_sexp(o_sexp), .o_last(o_last),
    .fin(fin), .done(done)
  );
endmodule

// File: rtl/fp8x_xpose_chk.sv
module fp8x_xpose_chk #(
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          ld_ready,
  input logic          o_valid,
  input logic          o_ready,
  input logic [7:0]    o_code,
  input logic [SW-1:0] o_sexp,
  input logic          o_last
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_code) && $stable(o_sexp) && $stable(o_last))); // R9

  AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_ready && o_last) |=> done); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(o_valid && o_ready && o_last)); // R10

  AST_READY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ld_ready); // R10

  AST_LOAD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> !ld_ready); // R1

  AST_SCALE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && $past(o_valid && !o_last)) |-> $stable(o_sexp)); // R3
endmodule

bind fp8x_blk_xpose fp8x_xpose_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .ld_ready(ld_ready),
  .o_valid(o_valid), .o_ready(o_ready), .o_code(o_code),
  .o_sexp(o_sexp), .o_last(o_last)
);

// File: tb/fp8x_blk_xpose_tb_top.sv
module fp8x_blk_xpose_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIM = 4;
  localparam int SW  = 8;
  localparam int NN  = DIM * DIM;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic [7:0]    ld_code = '0;
  logic [SW-1:0] ld_sexp = '0;
  logic          start = 1'b0;
  logic          done;
  logic          o_valid;
  logic          o_ready = 1'b1;
  logic [7:0]    o_code;
  logic [SW-1:0] o_sexp;
  logic          o_last;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int blocks_done = 0;
  int rdy_mode = 0;
  bit finished = 0;

  // reference model state
  int         m_phase = 0;
  int         m_cnt = 0;
  logic [7:0] m_code [NN];
  int         m_sc [DIM];
  bit         m_done = 0;
  bit         m_hold = 0;
  logic [7:0] h_code;
  logic [SW-1:0] h_sexp;
  logic       h_last;
  logic [7:0] q_code [$];
  int         q_sc [$];
  bit         q_last [$];
  string      q_tag [$];

  // stimulus tile
  logic [7:0] blk_code [NN];
  int         blk_sc [DIM];

  fp8x_blk_xpose #(.DIM(DIM), .SW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_code(ld_code), .ld_sexp(ld_sexp), .start(start), .done(done),
    .o_valid(o_valid), .o_ready(o_ready), .o_code(o_code),
    .o_sexp(o_sexp), .o_last(o_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // value of a code in units of 2^-9, divided by 2^k, re-encoded exactly
  function automatic logic [7:0] ref_shift(input logic [7:0] c, input int k,
                                           output string tag);
    longint units, u, ip, fr, half;
    int e;
    if (c[6:0] == 7'h7F || c[6:0] == 7'h00) begin
      tag = "R7";
      return c;
    end
    if (c[6:3] == 4'd0) begin
      units = longint'(c[2:0]);
      tag = "R7";
    end else begin
      units = longint'(8 + c[2:0]) << (c[6:3] - 1);
      tag = "R5";
    end
    if (k > 40) u = 0;
    else u = (units << 24) >> k;
    ip = u >> 24;
    fr = u & ((longint'(1) << 24) - 1);
    half = longint'(1) << 23;
    if (ip >= 8) begin
      e = 1;
      while (ip >= (longint'(16) << (e - 1))) e++;
      return {c[7], 4'(e), 3'((ip >> (e - 1)) - 8)};
    end
    if (tag == "R5") tag = "R6";
    if (fr > half || (fr == half && ip[0])) ip++;
    return {c[7], 7'(ip)};
  endfunction

  // monitor and model, sampled mid-cycle
  always @(negedge clk) begin
    int p;
    int mx;
    string tg;
    logic [7:0] ec;
    if (rst_n && !finished) begin
      cycles++;
      p = m_phase;
      check(ld_ready == (p == 0), "R1", "ld_ready", int'(ld_ready), int'(p == 0));
      check(done == m_done, "R10", "done", int'(done), int'(m_done));
      if (p != 2) check(o_valid == 1'b0, "R8", "o_valid idle", int'(o_valid), 0);
      if (m_hold) begin
        check(o_valid == 1'b1, "R9", "o_valid held", int'(o_valid), 1);
        check(o_code == h_code, "R9", "o_code held", int'(o_code), int'(h_code));
        check(o_sexp == h_sexp && o_last == h_last, "R9", "o_sexp/o_last held",
              int'(o_sexp), int'(h_sexp));
      end
      m_done = 0;
      if (o_valid && o_ready) begin
        if (q_code.size() == 0) begin
          check(1'b0, "R4", "unexpected beat", int'(o_code), -1);
        end else begin
          tg = q_tag.pop_front();
          ec = q_code.pop_front();
          check(o_code == ec, tg, "o_code", int'(o_code), int'(ec));
          mx = q_sc.pop_front();
          check($signed(o_sexp) == mx, "R3", "o_sexp", int'($signed(o_sexp)), mx);
          begin
            bit el;
            el = q_last.pop_front();
            check(o_last == el, "R4", "o_last", int'(o_last), int'(el));
          end
        end
        if (o_last) begin
          m_done = 1;
          m_phase = 0;
          m_cnt = 0;
          blocks_done++;
        end
      end
      m_hold = o_valid && !o_ready;
      h_code = o_code;
      h_sexp = o_sexp;
      h_last = o_last;
      if (p == 0 && ld_valid) begin
        m_code[m_cnt] = ld_code;
        if (m_cnt % DIM == 0) m_sc[m_cnt / DIM] = int'($signed(ld_sexp));
        m_cnt++;
        if (m_cnt == NN) m_phase = 1;
      end
      if (p == 1 && start) begin
        mx = m_sc[0];
        for (int r = 1; r < DIM; r++) if (m_sc[r] > mx) mx = m_sc[r];
        for (int c = 0; c < DIM; c++) begin
          for (int r = 0; r < DIM; r++) begin
            ec = ref_shift(m_code[r*DIM + c], mx - m_sc[r], tg);
            q_code.push_back(ec);
            q_tag.push_back(tg);
            q_sc.push_back(mx);
            q_last.push_back(c == DIM-1 && r == DIM-1);
          end
        end
        m_phase = 2;
      end
      if (cycles > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        finished = 1;
        $finish;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    o_ready = (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
  end

  task automatic load_blk(input bit poke_start);
    bit acc;
    for (int i = 0; i < NN; i++) begin
      if (($urandom % 4) == 0) begin
        ld_valid = 1'b0;
        @(posedge clk); #1;
      end
      ld_valid = 1'b1;
      ld_code  = blk_code[i];
      // R2: garbage exponent on every beat other than column 0
      ld_sexp  = (i % DIM == 0) ? SW'(blk_sc[i / DIM]) : SW'($urandom);
      start    = (poke_start && i == 5);
      do begin
        @(negedge clk);
        acc = ld_ready;
        @(posedge clk); #1;
        start = 1'b0;
      end while (!acc);
    end
    ld_valid = 1'b0;
  endtask

  task automatic run_blk(input bit pokes);
    int b0;
    b0 = blocks_done;
    load_blk(pokes);
    // offers while the tile is full must be refused (R1)
    ld_valid = 1'b1;
    ld_code  = 8'h55;
    repeat (2) begin @(posedge clk); #1; end
    ld_valid = 1'b0;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (pokes) begin
      repeat (3) begin @(posedge clk); #1; end
      start = 1'b1;  // R8: ignored during read-out
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (blocks_done == b0) begin @(posedge clk); #1; end
    repeat (2) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(ld_ready == 1'b1, "R11", "ld_ready after reset", int'(ld_ready), 1);
    check(o_valid == 1'b0, "R11", "o_valid after reset", int'(o_valid), 0);
    check(done == 1'b0, "R11", "done after reset", int'(done), 0);
    @(posedge clk); #1;

    // tile A: equal scales, special codes pass through (R5, R7)
    for (int i = 0; i < NN; i++) blk_code[i] = 8'($urandom);
    blk_code[0] = 8'h00; blk_code[1] = 8'h80; blk_code[2] = 8'h7F;
    blk_code[3] = 8'hFF; blk_code[4] = 8'h01; blk_code[5] = 8'h7E;
    for (int r = 0; r < DIM; r++) blk_sc[r] = 5;
    run_blk(1'b0);

    // tile B: mixed scales with stalls and stray starts (R3, R5, R8, R9)
    rdy_mode = 1;
    for (int i = 0; i < NN; i++) blk_code[i] = 8'($urandom);
    blk_sc[0] = 3; blk_sc[1] = 0; blk_sc[2] = -2; blk_sc[3] = 1;
    run_blk(1'b1);

    // tile C: huge gaps flush to signed zero (R6)
    for (int i = 0; i < NN; i++) blk_code[i] = 8'($urandom);
    blk_sc[0] = -120; blk_sc[1] = 120; blk_sc[2] = 0; blk_sc[3] = -5;
    run_blk(1'b0);

    // tile D: directed rounding ties and subnormal carries, k = 1 (R6, R7)
    blk_sc[0] = 1; blk_sc[1] = 0; blk_sc[2] = 0; blk_sc[3] = 0;
    blk_code[0] = 8'h3C; blk_code[1] = 8'hC1; blk_code[2] = 8'h08; blk_code[3] = 8'h01;
    blk_code[4] = 8'h03; blk_code[5] = 8'h01; blk_code[6] = 8'h05; blk_code[7] = 8'h87;
    blk_code[8] = 8'h08; blk_code[9] = 8'h0F; blk_code[10] = 8'h10; blk_code[11] = 8'h8F;
    blk_code[12] = 8'hFF; blk_code[13] = 8'h80; blk_code[14] = 8'h7E; blk_code[15] = 8'h00;
    run_blk(1'b1);

    // further random tiles under back-pressure (R2, R4, R6)
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < NN; i++) blk_code[i] = 8'($urandom);
      for (int r = 0; r < DIM; r++) blk_sc[r] = int'($urandom % 13) - 6;
      run_blk(t[0]);
    end

    check(q_code.size() == 0, "R4", "leftover beats", q_code.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule